// File: doc/BRIEF.md
# Crosstalk-Aware Variable-Cycle Transmitter

This block drives words onto an N-bit parallel on-chip bus and chooses, for each new word, how long it stays on the wires before the receiver may sample it. Each wire gets a transition: rise, fall or quiet. The block then compares that transition with the ones on the wire's two neighbours and gives the wire a crosstalk class. The class follows the coupling term of the distributed-RC delay. A wire whose neighbours move with it costs nothing extra. A quiet neighbour adds one coupling unit, and a neighbour moving the other way adds two. The worst class on the bus becomes a hold code of 3, 4, 5 or 6. The word is held for that many unit clock cycles, and a one-cycle Ready pulse in the last held cycle tells the far end that the word has settled.

Words arrive on a valid/ready stream. The analysis is combinational between the incoming word and the registered bus word, so it adds no cycle of its own. A word is launched on the edge where it is accepted. The hold code is also presented on an output so that a neighbouring counter can add up the cycles saved against the worst-case period.

The controller has two states. TX_IDLE means the bus is quiet and a word may be accepted. TX_HOLD means a word is being held. The transitions are as follows. LAUNCH goes from TX_IDLE to TX_HOLD when a word is accepted. COUNT stays in TX_HOLD while the hold counter is above zero. CHAIN stays in TX_HOLD when a new word is accepted in the last held cycle. RELEASE goes from TX_HOLD to TX_IDLE in the last held cycle when no word is offered.

Top module: `xtalk_vct_tx`

## Requirements
- R1: After reset, bus_data is all zeros, bus_rdy is low, xt_code is 3 and in_ready is high.
- R2: A wire's transition is +1 when its bit goes 0 to 1, -1 when it goes 1 to 0, and 0 when it is unchanged. A wire with transition 0 is class 1, so a word equal to the bus word gets code 3.
- R3: A switching wire has class 2 plus the sum of one term for each neighbour. The term is 0 if the neighbour switches in the same direction, 1 if it is quiet and 2 if it switches the opposite way. A middle wire switching against both neighbours is therefore class 6.
- R4: A wire whose neighbours both switch in its own direction is class 2, which carries no coupling penalty and maps to code 3.
- R5: Wire 0 and wire N-1 treat their missing outer neighbour as quiet. For example, only wire 0 rising on an otherwise quiet bus is class 4.
- R6: The bus class is the maximum class over all wires. xt_code, a 3-bit binary value, is 3 for bus classes 1 to 3 and equals the class for 4, 5 and 6. It is updated on the accepting edge and stays stable until the next acceptance.
- R7: An accepted word appears on bus_data in the cycle after the accepting edge. It is held for exactly xt_code cycles, and bus_rdy is high only in the last of them.
- R8: in_ready is low in every held cycle except the last. A word offered while in_ready is low is not taken. A word offered in the last held cycle is accepted, so the next hold starts without an idle cycle.
- R9: While no word is offered after a hold, bus_data keeps the last word and bus_rdy stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Unit-period clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Source offers a word |
| in_data | input | BUS_W | Offered word |
| in_ready | output | 1 | Block takes the offered word on this edge |
| bus_data | output | BUS_W | Word driven on the bus wires |
| bus_rdy | output | 1 | Ready wire: the held word is valid at the receiver |
| xt_code | output | 3 | Hold code (3 to 6) of the word on the bus |

## Verification
The hardest situation to reach from the ports is a given class on a given wire, because it depends on the word already on the bus as well as on the new one. The worst class also appears only when three adjacent wires alternate in both words. The bench uses a 4-bit bus and visits every ordered pair of bus word and next word by sending the first word and then the second. It therefore covers every neighbour pattern, including both edge wires. During each hold it keeps offering a decoy word, so that stalls are exercised. The next word is always offered in the last held cycle, which exercises the CHAIN transition on every word.

// File: rtl/xvct_pkg.sv
package xvct_pkg;

    localparam int CLS_W = 3;

    typedef enum logic [0:0] {
        TX_IDLE = 1'b0,
        TX_HOLD = 1'b1
    } tx_state_e;

    typedef enum logic [1:0] {
        TR_NONE = 2'd0,
        TR_RISE = 2'd1,
        TR_FALL = 2'd2
    } trans_e;

    // coupling units a neighbour adds to a switching wire
    function automatic logic [CLS_W-1:0] nb_cost(trans_e mid, trans_e nb);
        if (nb == TR_NONE) return 3'd1;
        if (nb == mid)     return 3'd0;
        return 3'd2;
    endfunction

    function automatic trans_e edge_of(logic old_b, logic new_b);
        if (old_b == new_b) return TR_NONE;
        return new_b ? TR_RISE : TR_FALL;
    endfunction

endpackage

// File: rtl/xvct_wire_class.sv
module xvct_wire_class
    import xvct_pkg::*;
(
    input  trans_e                left_t,
    input  trans_e                mid_t,
    input  trans_e                right_t,
    output logic [CLS_W-1:0]      cls
);

    always_comb begin
        if (mid_t == TR_NONE) begin
            cls = 3'd1;
        end else begin
            cls = 3'd2 + nb_cost(mid_t, left_t) + nb_cost(mid_t, right_t);
        end
    end

endmodule

// File: rtl/xvct_class_array.sv
module xvct_class_array
    import xvct_pkg::*;
#(
    parameter int BUS_W = 32
) (
    input  logic [BUS_W-1:0]              cur_word,
    input  logic [BUS_W-1:0]              nxt_word,
    output logic [BUS_W-1:0][CLS_W-1:0]   wire_cls
);

    localparam int PAD_W = BUS_W + 2;

    // index 0 and PAD_W-1 are the quiet virtual wires beyond the edges
    trans_e tr [PAD_W];

    assign tr[0]       = TR_NONE;
    assign tr[PAD_W-1] = TR_NONE;

    for (genvar g = 0; g < BUS_W; g++) begin : g_wire
        assign tr[g+1] = edge_of(cur_word[g], nxt_word[g]);

        xvct_wire_class u_cls (
            .left_t  (tr[g]),
            .mid_t   (tr[g+1]),
            .right_t (tr[g+2]),
            .cls     (wire_cls[g])
        );
    end

endmodule

// File: rtl/xvct_max_code.sv
module xvct_max_code
    import xvct_pkg::*;
#(
    parameter int BUS_W = 32
) (
    input  logic [BUS_W-1:0][CLS_W-1:0] wire_cls,
    output logic [CLS_W-1:0]            code
);

    localparam logic [CLS_W-1:0] CODE_FLOOR = 3'd3;

    logic [CLS_W-1:0] worst;

    always_comb begin
        worst = 3'd1;
        for (int i = 0; i < BUS_W; i++) begin
            if (wire_cls[i] > worst) worst = wire_cls[i];
        end
        code = (worst < CODE_FLOOR) ? CODE_FLOOR : worst;
    end

endmodule

// File: rtl/xvct_hold_fsm.sv
module xvct_hold_fsm
    import xvct_pkg::*;
#(
    parameter int BUS_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  logic [BUS_W-1:0]    in_data,
    input  logic [CLS_W-1:0]    nxt_code,
    output logic                in_ready,
    output logic [BUS_W-1:0]    bus_data,
    output logic                bus_rdy,
    output logic [CLS_W-1:0]    xt_code
);

    tx_state_e        state_q, state_d;
    logic [CLS_W-1:0] cnt_q;
    logic             last_cyc;
    logic             take;

    assign last_cyc = (cnt_q == '0);
    assign take     = in_valid && in_ready;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= TX_IDLE;
        else        state_q <= state_d;
    end

    // next state: LAUNCH, COUNT, CHAIN, RELEASE
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TX_IDLE: if (take) state_d = TX_HOLD;
            TX_HOLD: begin
                if (last_cyc) state_d = take ? TX_HOLD : TX_IDLE;
                else          state_d = TX_HOLD;
            end
            default: state_d = TX_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        in_ready = 1'b0;
        bus_rdy  = 1'b0;
        unique case (state_q)
            TX_IDLE: in_ready = 1'b1;
            TX_HOLD: begin
                in_ready = last_cyc;
                bus_rdy  = last_cyc;
            end
            default: in_ready = 1'b0;
        endcase
    end

    // word, code and hold counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bus_data <= '0;
            xt_code  <= 3'd3;
            cnt_q    <= '0;
        end else if (take) begin
            bus_data <= in_data;
            xt_code  <= nxt_code;
            cnt_q    <= nxt_code - 3'd1;
        end else if (state_q == TX_HOLD && !last_cyc) begin
            cnt_q    <= cnt_q - 3'd1;
        end
    end

endmodule

// File: rtl/xtalk_vct_tx.sv
module xtalk_vct_tx #(
    parameter int BUS_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [BUS_W-1:0]  in_data,
    output logic              in_ready,
    output logic [BUS_W-1:0]  bus_data,
    output logic              bus_rdy,
    output logic [2:0]        xt_code
);

    logic [BUS_W-1:0][2:0] wire_cls;
    logic [2:0]            nxt_code;

    xvct_class_array #(.BUS_W(BUS_W)) u_array (
        .cur_word (bus_data),
        .nxt_word (in_data),
        .wire_cls (wire_cls)
    );

    xvct_max_code #(.BUS_W(BUS_W)) u_max (
        .wire_cls (wire_cls),
        .code     (nxt_code)
    );

    xvct_hold_fsm #(.BUS_W(BUS_W)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_data  (in_data),
        .nxt_code (nxt_code),
        .in_ready (in_ready),
        .bus_data (bus_data),
        .bus_rdy  (bus_rdy),
        .xt_code  (xt_code)
    );

endmodule

// File: rtl/xtalk_vct_tx_chk.sv
module xtalk_vct_tx_chk #(
    parameter int BUS_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              in_ready,
    input logic [BUS_W-1:0]  bus_data,
    input logic              bus_rdy,
    input logic [2:0]        xt_code
);

    assert_code_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (xt_code >= 3'd3) && (xt_code <= 3'd6));

    assert_code_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_valid && in_ready) |=> $stable(xt_code));

    assert_rdy_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rdy |=> !bus_rdy);

    assert_launch_no_rdy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> !bus_rdy);

    assert_rdy_allows_chain_R8: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rdy |-> in_ready);

    assert_bus_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_valid && in_ready) |=> $stable(bus_data));

endmodule

bind xtalk_vct_tx xtalk_vct_tx_chk #(.BUS_W(BUS_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .bus_data (bus_data),
    .bus_rdy  (bus_rdy),
    .xt_code  (xt_code)
);

// File: tb/test_xtalk_vct_tx.sv
module test_xtalk_vct_tx;

    localparam int W = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [W-1:0] in_data = '0;
    logic         in_ready;
    logic [W-1:0] bus_data;
    logic         bus_rdy;
    logic [2:0]   xt_code;

    int checks = 0;
    int errors = 0;
    logic [W-1:0] model_bus = '0;

    always #5 clk = ~clk;

    xtalk_vct_tx #(.BUS_W(W)) i_xtalk_vct_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_data  (in_data),
        .in_ready (in_ready),
        .bus_data (bus_data),
        .bus_rdy  (bus_rdy),
        .xt_code  (xt_code)
    );

    task automatic check(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // delay coefficient of lambda: 2 - d*dl - d*dr ; class = 2 + that
    function automatic int ref_code(logic [W-1:0] a, logic [W-1:0] b);
        int d [W];
        int mx = 3;
        for (int i = 0; i < W; i++) d[i] = int'(b[i]) - int'(a[i]);
        for (int i = 0; i < W; i++) begin
            int dl, dr, c;
            if (d[i] != 0) begin
                dl = (i > 0)     ? d[i-1] : 0;
                dr = (i < W - 1) ? d[i+1] : 0;
                c  = 2 + (2 - d[i]*dl - d[i]*dr);
                if (c > mx) mx = c;
            end
        end
        return mx;
    endfunction

    // entered and left at a falling edge; next word is offered at once
    task automatic send(logic [W-1:0] w, int exp, string req);
        int n;
        in_valid = 1'b1;
        in_data  = w;
        while (!in_ready) @(negedge clk);
        @(negedge clk);
        n = 1;
        check(bus_data == w, "R7 word on bus", int'(bus_data), int'(w));
        check(xt_code == 3'(exp), req, int'(xt_code), exp);
        forever begin
            if (bus_rdy) break;
            check(!in_ready, "R8 stall", int'(in_ready), 0);
            in_valid = 1'b1;
            in_data  = ~w;
            @(negedge clk);
            n++;
            check(bus_data == w, "R8 decoy not taken", int'(bus_data), int'(w));
            check(xt_code == 3'(exp), "R6 code stable", int'(xt_code), exp);
            if (n > 8) break;
        end
        check(n == exp, "R7 hold length", n, exp);
        in_valid = 1'b0;
        model_bus = w;
    endtask

    task automatic send_auto(logic [W-1:0] w);
        send(w, ref_code(model_bus, w), "R2 R3 R4 R5 R6 code");
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : stim
        repeat (3) @(negedge clk);
        check(bus_data == '0, "R1 bus zero", int'(bus_data), 0);
        check(bus_rdy == 1'b0, "R1 rdy low", int'(bus_rdy), 0);
        check(in_ready == 1'b1, "R1 in_ready", int'(in_ready), 1);
        check(xt_code == 3'd3, "R1 code", int'(xt_code), 3);
        rst_n = 1'b1;
        @(negedge clk);

        // directed corners
        send(4'b0000, 3, "R2 equal word");
        send(4'b0001, 4, "R5 edge wire lone rise");
        send(4'b0101, 4, "R5 spaced rises");
        send(4'b1010, 6, "R3 opposite both neighbours");
        send(4'b0101, 6, "R3 reverse alternation");
        send(4'b0000, 4, "R3 quiet neighbours");
        send(4'b1111, 3, "R4 all same direction");
        send(4'b1111, 3, "R2 no change");

        // idle gap
        repeat (4) begin
            @(negedge clk);
            check(bus_data == 4'b1111, "R9 bus kept", int'(bus_data), 15);
            check(!bus_rdy, "R9 no ready", int'(bus_rdy), 0);
        end

        // every ordered pair of bus word and next word
        for (int a = 0; a < (1 << W); a++) begin
            for (int b = 0; b < (1 << W); b++) begin
                send_auto(W'(a));
                send_auto(W'(b));
            end
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule